// File: doc/BRIEF.md
# Precision and integer conversion unit

This block converts a floating-point operand between single and double precision in either direction, and turns a single or double value into a signed 32-bit or 64-bit integer. One operation is accepted on each cycle in which `in_valid` is high. The registered result, its flags and a fault request appear on the next cycle.

NaN operands follow fixed rules. When a NaN changes format, its exponent field is replaced and 29 significand bits are appended or removed. A signaling NaN is made quiet and raises invalid. A quiet NaN passes through with no flag. A conversion to integer that meets a NaN, an infinity or a value out of range yields the integer-indefinite pattern and raises invalid. If invalid is unmasked, the block delivers no result and requests a fault instead.

Narrowing of finite values rounds to nearest even. Values too large for single precision saturate to a signed infinity. Values too small for a single-precision normal flush to a signed zero. Integer conversion either truncates toward zero or rounds to nearest even, as the caller selects.

Top module: `cvt_unit`

## Requirements
- R1: The operation code `in_op` selects the conversion: 0 widens `in_operand[31:0]` to double, 1 narrows `in_operand` to single, 2 converts `in_operand[31:0]` (single) to integer, 3 converts `in_operand` (double) to integer. The outputs of an operation are registered and appear exactly one cycle after the cycle with `in_valid` high. In a cycle after one with `in_valid` low, `out_valid` and `fault_req` are both low.
- R2: Widening a finite single value is exact and raises no flag. A normal value is rebiased and its fraction is shifted up 29 bits. Infinity stays infinity with its sign. A single denormal flushes to a double zero with the same sign.
- R3: Widening a NaN keeps the sign, writes exponent 0x7FF and places the 23-bit fraction above 29 zero bits. If fraction bit 22 was 0 (signaling), result bit 51 is set and invalid is raised. A quiet NaN raises no flag.
- R4: Narrowing a NaN keeps the sign, writes exponent 0xFF and keeps fraction bits 51..29. If bit 51 was 0 (signaling), result bit 22 is set and invalid is raised. Bits 63..32 of a narrowed result are always zero.
- R5: Narrowing a finite double in the single normal range rounds the fraction to 23 bits by round-to-nearest-even. Inexact is set whenever a nonzero bit is discarded.
- R6: A narrowed finite value that reaches single exponent 255 after rounding, including through a rounding carry, returns a signed infinity with both overflow and inexact set. A double whose single exponent would be 0 or lower flushes to a signed zero with inexact set.
- R7: Integer conversion returns a 64-bit result when `in_int64` is 1. Otherwise it returns a 32-bit result in bits 31..0 with bits 63..32 zero. With `in_trunc` set it rounds toward zero; with `in_trunc` clear it rounds to nearest even. Any discarded fraction sets inexact.
- R8: A NaN or infinity, or a rounded value outside the signed range of the selected width, yields integer-indefinite and raises invalid. Integer-indefinite is 0x80000000 for 32-bit results (bits 63..32 zero) and 0x8000000000000000 for 64-bit results. The exact most-negative value converts normally, with no flag.
- R9: When an operation raises invalid and `invalid_mask` is 0, the next cycle shows `fault_req` high, `out_valid` low, `out_result` zero and `out_invalid` high. When `invalid_mask` is 1, the masked result is delivered with `out_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 2 | Conversion select (see R1) |
| in_operand | input | 64 | Source value; single sources use bits 31..0 |
| in_trunc | input | 1 | Integer conversion truncates toward zero when 1 |
| in_int64 | input | 1 | Integer result is 64-bit when 1, 32-bit when 0 |
| invalid_mask | input | 1 | 1 masks invalid, 0 turns invalid into a fault request |
| out_valid | output | 1 | Result delivered this cycle |
| out_result | output | 64 | Converted value |
| out_invalid | output | 1 | Invalid raised by the operation |
| out_inexact | output | 1 | Inexact raised by the operation |
| out_overflow | output | 1 | Overflow raised by a narrowing |
| fault_req | output | 1 | Unmasked invalid: no result, fault requested |

## Verification
Every output is held in one register stage, so the result of an operation is due on the first rising edge after the cycle in which `in_valid` was high, and only then. The bench changes inputs on the falling edge and holds them for one full period. It then reads all outputs on the following falling edge, half a period after the edge that loaded them, so each comparison sees a single settled operation. Idle cycles are read the same way, to confirm that `out_valid` and `fault_req` drop one cycle after `in_valid` does.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  localparam int SP_W    = 32;
  localparam int DP_W    = 64;
  localparam int SP_FRAC = 23;
  localparam int DP_FRAC = 52;
  localparam int SP_BIAS = 127;
  localparam int DP_BIAS = 1023;
  localparam int FRAC_GAP = DP_FRAC - SP_FRAC;          // 29
  localparam int REBIAS   = DP_BIAS - SP_BIAS;          // 896

  typedef enum logic [1:0] {
    OP_WIDEN  = 2'd0,
    OP_NARROW = 2'd1,
    OP_S2I    = 2'd2,
    OP_D2I    = 2'd3
  } cvt_op_e;

  typedef struct packed {
    logic [DP_W-1:0] value;
    logic            invalid;
    logic            inexact;
    logic            overflow;
  } cvt_res_t;

  // single -> double
  function automatic cvt_res_t widen_f(input logic [SP_W-1:0] s);
    cvt_res_t r;
    logic [7:0]  e;
    logic [22:0] f;
    r = '0;
    e = s[30:23];
    f = s[22:0];
    if (e == 8'hFF) begin
      if (f == '0) begin
        r.value = {s[31], 11'h7FF, 52'd0};
      end else begin
        r.value = {s[31], 11'h7FF, f, 29'd0};
        r.value[51] = 1'b1;
        r.invalid = ~f[22];
      end
    end else if (e == 8'h00) begin
      r.value = {s[31], 63'd0};
    end else begin
      r.value = {s[31], ({3'd0, e} + 11'(REBIAS)), f, 29'd0};
    end
    return r;
  endfunction

  // double -> single, round to nearest even
  function automatic cvt_res_t narrow_f(input logic [DP_W-1:0] d);
    cvt_res_t    r;
    logic        sgn;
    logic [10:0] e;
    logic [51:0] f;
    logic [11:0] te;
    logic        g, st, up;
    logic [34:0] sum;
    r   = '0;
    sgn = d[63];
    e   = d[62:52];
    f   = d[51:0];
    g   = f[28];
    st  = |f[27:0];
    up  = g & (st | f[29]);
    te  = {1'b0, e} - 12'(REBIAS);
    sum = {te, f[51:29]} + {34'd0, up};
    if (e == 11'h7FF) begin
      if (f == '0) begin
        r.value = {32'd0, sgn, 8'hFF, 23'd0};
      end else begin
        r.value = {32'd0, sgn, 8'hFF, f[51:29]};
        r.value[22] = 1'b1;
        r.invalid = ~f[51];
      end
    end else if (e == 11'd0) begin
      r.value   = {32'd0, sgn, 31'd0};
      r.inexact = |f;
    end else if (e <= 11'(REBIAS)) begin
      r.value   = {32'd0, sgn, 31'd0};
      r.inexact = 1'b1;
    end else if (sum[34:23] >= 12'd255) begin
      r.value    = {32'd0, sgn, 8'hFF, 23'd0};
      r.overflow = 1'b1;
      r.inexact  = 1'b1;
    end else begin
      r.value   = {32'd0, sgn, sum[30:0]};
      r.inexact = g | st;
    end
    return r;
  endfunction

  // single or double -> signed integer
  function automatic cvt_res_t to_int_f(input logic is_dbl, input logic [DP_W-1:0] x,
                                        input logic trunc, input logic w64);
    cvt_res_t     r;
    logic         sgn, special, big, g, st, up, oob;
    logic [52:0]  sig;
    int           e;
    logic [180:0] sh;
    logic [64:0]  mag, lim;
    logic [63:0]  sv;
    r = '0;
    if (is_dbl) begin
      sgn     = x[63];
      special = &x[62:52];
      sig     = {|x[62:52], x[51:0]};
      e       = (x[62:52] == 11'd0) ? (1 - DP_BIAS) : (int'(x[62:52]) - DP_BIAS);
    end else begin
      sgn     = x[31];
      special = &x[30:23];
      sig     = {|x[30:23], x[22:0], 29'd0};
      e       = (x[30:23] == 8'd0) ? (1 - SP_BIAS) : (int'(x[30:23]) - SP_BIAS);
    end
    big = 1'b0;
    g   = 1'b0;
    st  = 1'b0;
    mag = '0;
    sh  = '0;
    if (e >= 64) begin
      big = 1'b1;
    end else if (e >= DP_FRAC) begin
      mag = {12'd0, sig} << (e - DP_FRAC);
    end else if ((DP_FRAC - e) > 116) begin
      st = |sig;
    end else begin
      sh  = {sig, 128'd0} >> (DP_FRAC - e);
      mag = {12'd0, sh[180:128]};
      g   = sh[127];
      st  = |sh[126:0];
    end
    up  = ~trunc & g & (st | mag[0]);
    mag = mag + {64'd0, up};
    lim = w64 ? (65'd1 << 63) : (65'd1 << 31);
    oob = big | special | (sgn ? (mag > lim) : (mag >= lim));
    sv  = sgn ? (~mag[63:0] + 64'd1) : mag[63:0];
    if (oob) begin
      r.value   = w64 ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
      r.invalid = 1'b1;
    end else begin
      r.value   = w64 ? sv : {32'd0, sv[31:0]};
      r.inexact = g | st;
    end
    return r;
  endfunction

endpackage

// File: rtl/cvt_widen.sv
module cvt_widen
  import cvt_pkg::*;
(
  input  logic [SP_W-1:0] src,
  output cvt_res_t        res
);
  assign res = widen_f(src);
endmodule

// File: rtl/cvt_narrow.sv
module cvt_narrow
  import cvt_pkg::*;
(
  input  logic [DP_W-1:0] src,
  output cvt_res_t        res
);
  assign res = narrow_f(src);
endmodule

// File: rtl/cvt_to_int.sv
module cvt_to_int
  import cvt_pkg::*;
(
  input  logic            is_dbl,
  input  logic [DP_W-1:0] src,
  input  logic            trunc,
  input  logic            w64,
  output cvt_res_t        res
);
  assign res = to_int_f(is_dbl, src, trunc, w64);
endmodule

// File: rtl/cvt_unit.sv
module cvt_unit
  import cvt_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_operand,
  input  logic              in_trunc,
  input  logic              in_int64,
  input  logic              invalid_mask,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic              out_overflow,
  output logic              fault_req
);

  localparam int HALF_W = DATA_W / 2;

  cvt_op_e  op;
  cvt_res_t res_widen, res_narrow, res_int, sel_res;
  logic     sel_invalid;
  logic     fault_event;
  logic     deliver_event;

  assign op = cvt_op_e'(in_op);

  cvt_widen u_widen (
    .src (in_operand[HALF_W-1:0]),
    .res (res_widen)
  );

  cvt_narrow u_narrow (
    .src (in_operand),
    .res (res_narrow)
  );

  cvt_to_int u_to_int (
    .is_dbl (op == OP_D2I),
    .src    (in_operand),
    .trunc  (in_trunc),
    .w64    (in_int64),
    .res    (res_int)
  );

  always_comb begin
    case (op)
      OP_WIDEN:  sel_res = res_widen;
      OP_NARROW: sel_res = res_narrow;
      default:   sel_res = res_int;
    endcase
  end

  assign sel_invalid   = sel_res.invalid;
  assign fault_event   = in_valid & sel_invalid & ~invalid_mask;
  assign deliver_event = in_valid & ~fault_event;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      fault_req    <= 1'b0;
      out_result   <= '0;
      out_invalid  <= 1'b0;
      out_inexact  <= 1'b0;
      out_overflow <= 1'b0;
    end else begin
      out_valid    <= deliver_event;
      fault_req    <= fault_event;
      out_invalid  <= in_valid & sel_res.invalid;
      out_inexact  <= deliver_event & sel_res.inexact;
      out_overflow <= deliver_event & sel_res.overflow;
      if (in_valid) begin
        out_result <= fault_event ? '0 : sel_res.value;
      end
    end
  end

endmodule

// File: rtl/cvt_unit_chk.sv
module cvt_unit_chk
  import cvt_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [1:0]  in_op,
  input logic [63:0] in_operand,
  input logic        in_int64,
  input logic        invalid_mask,
  input logic        sel_invalid,
  input logic        out_valid,
  input logic [63:0] out_result,
  input logic        out_invalid,
  input logic        out_inexact,
  input logic        out_overflow,
  input logic        fault_req
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !fault_req));

  a_r1_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !(sel_invalid && !invalid_mask)) |=> out_valid);

  a_r9_fault_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_invalid && !invalid_mask) |=>
      (fault_req && !out_valid && out_invalid && out_result == 64'd0));

  a_r9_fault_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> (!out_valid && out_invalid));

  a_r6_overflow_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> (out_inexact && !out_invalid));

  a_r3_qnan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_WIDEN && in_operand[30:23] == 8'hFF && in_operand[22])
      |=> (out_valid && !out_invalid && out_result[62:51] == 12'hFFF));

  a_r8_nan_indefinite: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && invalid_mask && in_int64 && in_op == OP_D2I && in_operand[62:52] == 11'h7FF)
      |=> (out_invalid && out_result == 64'h8000_0000_0000_0000));

  a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_NARROW) |=> (out_result[63:32] == 32'd0));

endmodule

bind cvt_unit cvt_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_op        (in_op),
  .in_operand   (in_operand),
  .in_int64     (in_int64),
  .invalid_mask (invalid_mask),
  .sel_invalid  (sel_invalid),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_invalid  (out_invalid),
  .out_inexact  (out_inexact),
  .out_overflow (out_overflow),
  .fault_req    (fault_req)
);

// File: tb/tb_cvt_unit.sv
module tb_cvt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [3:0]  tag;
    logic [1:0]  op;
    logic [63:0] opnd;
    logic        trunc;
    logic        w64;
    logic [63:0] res;
    logic        inv;
    logic        inx;
    logic        ovf;
  } vec_t;

  localparam int NVEC = 30;
  localparam vec_t VEC [NVEC] = '{
    // R2 widen normals, denormal, infinity
    '{4'd2, 2'd0, 64'h3F80_0000, 1'b0, 1'b0, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd2, 2'd0, 64'hC020_0000, 1'b0, 1'b0, 64'hC004_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd2, 2'd0, 64'h8000_0001, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd2, 2'd0, 64'h7F80_0000, 1'b0, 1'b0, 64'h7FF0_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    // R3 widen quiet and signaling NaN
    '{4'd3, 2'd0, 64'hFFC0_0001, 1'b0, 1'b0, 64'hFFF8_0000_2000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd3, 2'd0, 64'h7F80_0001, 1'b0, 1'b0, 64'h7FF8_0000_2000_0000, 1'b1, 1'b0, 1'b0},
    // R4 narrow quiet and signaling NaN
    '{4'd4, 2'd1, 64'hFFF8_0000_0000_0000, 1'b0, 1'b0, 64'hFFC0_0000, 1'b0, 1'b0, 1'b0},
    '{4'd4, 2'd1, 64'h7FF0_0000_2000_0001, 1'b0, 1'b0, 64'h7FC0_0001, 1'b1, 1'b0, 1'b0},
    // R5 narrow rounding
    '{4'd5, 2'd1, 64'h3FF0_0000_0000_0000, 1'b0, 1'b0, 64'h3F80_0000, 1'b0, 1'b0, 1'b0},
    '{4'd5, 2'd1, 64'h3FF0_0000_1000_0000, 1'b0, 1'b0, 64'h3F80_0000, 1'b0, 1'b1, 1'b0},
    '{4'd5, 2'd1, 64'h3FF0_0000_3000_0000, 1'b0, 1'b0, 64'h3F80_0002, 1'b0, 1'b1, 1'b0},
    '{4'd5, 2'd1, 64'h3FF0_0000_1000_0001, 1'b0, 1'b0, 64'h3F80_0001, 1'b0, 1'b1, 1'b0},
    // R6 overflow, rounding carry into overflow, flush to zero
    '{4'd6, 2'd1, 64'h7E37_E43C_8800_759C, 1'b0, 1'b0, 64'h7F80_0000, 1'b0, 1'b1, 1'b1},
    '{4'd6, 2'd1, 64'h47EF_FFFF_F000_0000, 1'b0, 1'b0, 64'h7F80_0000, 1'b0, 1'b1, 1'b1},
    '{4'd6, 2'd1, 64'h3800_0000_0000_0000, 1'b0, 1'b0, 64'h0000_0000, 1'b0, 1'b1, 1'b0},
    '{4'd6, 2'd1, 64'hB800_0000_0000_0000, 1'b0, 1'b0, 64'h8000_0000, 1'b0, 1'b1, 1'b0},
    // R7 integer rounding modes and widths
    '{4'd7, 2'd3, 64'h4004_0000_0000_0000, 1'b1, 1'b0, 64'h0000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd3, 64'h4004_0000_0000_0000, 1'b0, 1'b0, 64'h0000_0000_0000_0002, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd3, 64'h400C_0000_0000_0000, 1'b0, 1'b0, 64'h0000_0000_0000_0004, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd3, 64'hC004_0000_0000_0000, 1'b0, 1'b0, 64'h0000_0000_FFFF_FFFE, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd2, 64'hBFC0_0000, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd3, 64'h43D0_0000_0000_0000, 1'b0, 1'b1, 64'h4000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd7, 2'd2, 64'h3F00_0000, 1'b0, 1'b0, 64'h0000_0000_0000_0000, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd2, 64'h3F40_0000, 1'b0, 1'b0, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 1'b0},
    '{4'd7, 2'd3, 64'h41DF_FFFF_FFE0_0000, 1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b1, 1'b0},
    // R8 range edges, rounding out of range, NaN and infinity
    '{4'd8, 2'd3, 64'h41DF_FFFF_FFE0_0000, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd8, 2'd3, 64'hC3E0_0000_0000_0000, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd8, 2'd3, 64'h43E0_0000_0000_0000, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0},
    '{4'd8, 2'd3, 64'hC1E0_0000_0000_0000, 1'b1, 1'b0, 64'h0000_0000_8000_0000, 1'b0, 1'b0, 1'b0},
    '{4'd8, 2'd2, 64'h7F80_0000, 1'b0, 1'b1, 64'h8000_0000_0000_0000, 1'b1, 1'b0, 1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  in_op;
  logic [63:0] in_operand;
  logic        in_trunc;
  logic        in_int64;
  logic        invalid_mask;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_invalid;
  logic        out_inexact;
  logic        out_overflow;
  logic        fault_req;

  int n_checks = 0;
  int n_fails  = 0;

  cvt_unit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_op        (in_op),
    .in_operand   (in_operand),
    .in_trunc     (in_trunc),
    .in_int64     (in_int64),
    .invalid_mask (invalid_mask),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_invalid  (out_invalid),
    .out_inexact  (out_inexact),
    .out_overflow (out_overflow),
    .fault_req    (fault_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // packs {valid, fault, invalid, inexact, overflow, result}
  function automatic logic [68:0] observed();
    return {out_valid, fault_req, out_invalid, out_inexact, out_overflow, out_result};
  endfunction

  task automatic check(input string req, input logic [68:0] act, input logic [68:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual v/f/i/x/o/res=%b%b%b%b%b %h expected %b%b%b%b%b %h", req,
               act[68], act[67], act[66], act[65], act[64], act[63:0],
               exp[68], exp[67], exp[66], exp[65], exp[64], exp[63:0]);
    end
  endtask

  // drive on a falling edge, sample one period later on the next falling edge
  task automatic apply(input logic [1:0] op, input logic [63:0] opnd, input logic trunc,
                       input logic w64, input logic mask);
    @(negedge clk);
    in_valid     = 1'b1;
    in_op        = op;
    in_operand   = opnd;
    in_trunc     = trunc;
    in_int64     = w64;
    invalid_mask = mask;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_op = 2'd0;
    in_operand = '0;
    in_trunc = 1'b0;
    in_int64 = 1'b0;
    invalid_mask = 1'b1;
    repeat (3) @(negedge clk);
    // reset state, R1
    check("R1 reset", observed(), 69'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].op, VEC[i].opnd, VEC[i].trunc, VEC[i].w64, 1'b1);
      check($sformatf("R%0d vec%0d", VEC[i].tag, i), observed(),
            {1'b1, 1'b0, VEC[i].inv, VEC[i].inx, VEC[i].ovf, VEC[i].res});
    end

    // R1: idle cycle drops out_valid
    @(negedge clk);
    check("R1 idle", {observed()[68:67]}, 2'b00);

    // R9: unmasked signaling NaN narrow -> fault, no result
    apply(2'd1, 64'h7FF0_0000_2000_0001, 1'b0, 1'b0, 1'b0);
    check("R9 unmasked snan", observed(), {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 64'd0});

    // R9: unmasked out-of-range integer conversion -> fault
    apply(2'd3, 64'h43E0_0000_0000_0000, 1'b0, 1'b1, 1'b0);
    check("R9 unmasked range", observed(), {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 64'd0});

    // R9: unmasked but quiet NaN widen -> delivered, no fault
    apply(2'd0, 64'hFFC0_0001, 1'b0, 1'b0, 1'b0);
    check("R9 unmasked qnan", observed(),
          {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'hFFF8_0000_2000_0000});

    // R1: fault does not linger into an idle cycle
    @(negedge clk);
    check("R1 idle after fault", {observed()[68:67]}, 2'b00);

    // R1: back-to-back operations, each one cycle later
    @(negedge clk);
    in_valid = 1'b1; in_op = 2'd0; in_operand = 64'h3F80_0000; invalid_mask = 1'b1;
    @(negedge clk);
    check("R1 b2b first", observed(),
          {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h3FF0_0000_0000_0000});
    in_op = 2'd1; in_operand = 64'h3FF0_0000_0000_0000;
    @(negedge clk);
    check("R1 b2b second", observed(), {1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h3F80_0000});
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 b2b idle", {observed()[68:67]}, 2'b00);

    // R1: reset mid-run clears outputs
    apply(2'd1, 64'h7E37_E43C_8800_759C, 1'b0, 1'b0, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", observed(), 69'd0);
    rst_n = 1'b1;

    finish_run();
  end

endmodule